// File: doc/BRIEF.md
# Rule Table Range-Clear Engine

This block invalidates a contiguous, inclusive span of entries in a rule table on command. Software writes a single control word that carries a first index, a last index and a launch bit. Once launched, the engine steps through the span one entry per clock, driving a write strobe and an entry index to the valid-bit storage of the rule table. It never touches the rule contents.

The launch bit doubles as the busy flag. It reads back as 1 for as long as the walk is running, and software polls it until it reads 0. While the engine is busy, the lookup path is told to stall through a lookup-permit output that is held low, so a half-cleared table is never consulted. A bad span clears nothing and finishes at once. A bad span is one whose first index is above its last index, or whose last index lies past the table.

Top module: `rule_range_clear`

## Requirements
- R1: After reset the control readback is all zeros, no clear strobe is driven and the lookup permit is high.
- R2: Control word layout: bit 0 is the launch bit, bits 12:1 are the first index and bits 24:13 are the last index. On readback, bit 0 is the busy flag and bits 24:1 return the indices of the most recently accepted launch, including a rejected span. All other bits read 0.
- R3: After a valid launch, the busy flag reads 1 for exactly (last − first + 1) cycles and then returns to 0.
- R4: During a valid walk, the clear strobe is high once per cycle with indices first, first+1, … last in ascending order. It is low at every other time.
- R5: A span whose first index equals its last index clears exactly one entry.
- R6: A span from 0 to DEPTH−1 clears every entry of the table, where DEPTH = BLOCKS × BLK_ENTRIES.
- R7: If the first index is greater than the last index, no entry is cleared and the busy flag reads 1 for exactly one cycle.
- R8: If the last index is DEPTH or larger, no entry is cleared and the busy flag reads 1 for exactly one cycle.
- R9: A control write while busy is ignored. The walk in progress and the readback indices are unchanged.
- R10: The lookup permit is low in every cycle in which the busy flag reads 1.
- R11: A control write with the launch bit at 0 starts nothing and leaves the readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word written by software |
| ctl_rd_data | output | 32 | Control word readback (busy flag and latched indices) |
| clr_en | output | 1 | Clear strobe for the valid bit of one entry |
| clr_idx | output | IDX_W (12) | Index of the entry being cleared |
| lookup_ok | output | 1 | Lookup permit; low while the engine is busy |

## Verification
The bench targets the off-by-one edges of an inclusive walk. These are a single-entry span, a span that ends on the last table entry, and a whole-table span. A design with an exclusive end bound would drop the final index and shorten the busy time by one cycle. The bench also sends rejected spans (first above last, last past the table). A design that skipped the range test would strobe clears beyond the table or wrap the index. A second launch issued mid-walk checks that the span and readback are not overwritten, and a write with the launch bit at 0 checks that no walk starts.

// File: rtl/rrc_pkg.sv
// Shared definitions for the rule table range-clear engine.
// Assumes: control field positions are fixed by the software-visible layout.
package rrc_pkg;
    // Walk sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_REJECT = 2'd2
    } walk_state_e;

    // Bit position of the launch / busy flag
    localparam int LAUNCH_BIT = 0;
    // Lowest bit of the first-index field
    localparam int FIRST_LSB  = 1;
endpackage

// File: rtl/rrc_cmd_decode.sv
// Splits a control word into launch bit and indices and judges the span.
// Assumes: first index at FIRST_LSB, last index directly above it.
module rrc_cmd_decode
    import rrc_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int DEPTH = 256,
    localparam int CTRL_W = 2 * IDX_W + 1
) (
    input  logic [CTRL_W-1:0] word,
    output logic              launch,
    output logic [IDX_W-1:0]  first_idx,
    output logic [IDX_W-1:0]  last_idx,
    output logic              span_ok
);
    localparam int LAST_LSB = FIRST_LSB + IDX_W;

    // Field extraction and span legality test
    always_comb begin
        launch    = word[LAUNCH_BIT];
        first_idx = word[FIRST_LSB +: IDX_W];
        last_idx  = word[LAST_LSB +: IDX_W];
        span_ok   = (first_idx <= last_idx) && (32'(last_idx) < 32'(DEPTH));
    end
endmodule

// File: rtl/rrc_walker.sv
// Walk sequencer: steps one entry per cycle from first to last inclusive,
// or spends a single busy cycle on a rejected span.
// Assumes: start is only pulsed while idle.
module rrc_walker
    import rrc_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_ok,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    walk_state_e      state;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] end_q;

    // State, current index and end bound
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur_q <= '0;
            end_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= start_ok ? ST_WALK : ST_REJECT;
                        cur_q <= first_idx;
                        end_q <= last_idx;
                    end
                end
                ST_WALK: begin
                    if (cur_q == end_q) state <= ST_IDLE;
                    else                cur_q <= cur_q + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state
    always_comb begin
        busy    = (state != ST_IDLE);
        clr_en  = (state == ST_WALK);
        clr_idx = cur_q;
    end
endmodule

// File: rtl/rule_range_clear.sv
// Top of the range-clear engine: control register, span decode, walker,
// clear port and lookup stall.
// Assumes: DEPTH fits in IDX_W index bits; DATA_W holds the control fields.
module rule_range_clear
    import rrc_pkg::*;
#(
    parameter int IDX_W       = 12,
    parameter int BLOCKS      = 4,
    parameter int BLK_ENTRIES = 64,
    parameter int DATA_W      = 32,
    localparam int DEPTH  = BLOCKS * BLK_ENTRIES,
    localparam int CTRL_W = 2 * IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [DATA_W-1:0] ctl_wr_data,
    output logic [DATA_W-1:0] ctl_rd_data,
    output logic              clr_en,
    output logic [IDX_W-1:0]  clr_idx,
    output logic              lookup_ok
);
    logic             dec_launch;
    logic             dec_ok;
    logic [IDX_W-1:0] dec_first;
    logic [IDX_W-1:0] dec_last;
    logic             busy;
    logic             accept;
    logic [IDX_W-1:0] first_q;
    logic [IDX_W-1:0] last_q;
    logic             unused_hi_bits;

    assign unused_hi_bits = ^ctl_wr_data[DATA_W-1:CTRL_W];

    rrc_cmd_decode #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_dec (
        .word      (ctl_wr_data[CTRL_W-1:0]),
        .launch    (dec_launch),
        .first_idx (dec_first),
        .last_idx  (dec_last),
        .span_ok   (dec_ok)
    );

    // A launch is taken only from idle
    assign accept = ctl_wr_en && dec_launch && !busy;

    // Latch the indices of each accepted launch for readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
        end else if (accept) begin
            first_q <= dec_first;
            last_q  <= dec_last;
        end
    end

    rrc_walker #(.IDX_W(IDX_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_ok  (dec_ok),
        .first_idx (dec_first),
        .last_idx  (dec_last),
        .busy      (busy),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );

    // Readback word and lookup stall
    always_comb begin
        ctl_rd_data                         = '0;
        ctl_rd_data[LAUNCH_BIT]             = busy;
        ctl_rd_data[FIRST_LSB +: IDX_W]     = first_q;
        ctl_rd_data[FIRST_LSB+IDX_W +: IDX_W] = last_q;
        lookup_ok                           = !busy;
    end
endmodule

// File: rtl/rrc_checker.sv
// Temporal checks on the range-clear engine ports, bound to the top.
// Assumes: reset is held low for at least one clock at start.
module rrc_checker #(
    parameter int IDX_W  = 12,
    parameter int DEPTH  = 256,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr_en,
    input logic [DATA_W-1:0] ctl_rd_data,
    input logic              clr_en,
    input logic [IDX_W-1:0]  clr_idx,
    input logic              lookup_ok
);
    AST_CLR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> (32'(clr_idx) < 32'(DEPTH)));                          // R8
    AST_CLR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && $past(clr_en)) |-> (clr_idx == $past(clr_idx) + 1'b1)); // R4
    AST_CLR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> ctl_rd_data[0]);                                      // R3
    AST_LOOKUP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[0] |-> !lookup_ok);                                  // R10
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_rd_data[0]) |=> $stable(ctl_rd_data[2*IDX_W:1])); // R9
    AST_NO_BITS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[DATA_W-1:2*IDX_W+1] == '0);                          // R2
endmodule

bind rule_range_clear rrc_checker #(
    .IDX_W(IDX_W), .DEPTH(DEPTH), .DATA_W(DATA_W)
) u_rrc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_rd_data (ctl_rd_data),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx),
    .lookup_ok   (lookup_ok)
);

// File: tb/tb_rule_range_clear.sv
// Scoreboard bench: the driver queues expected clear indices, a monitor
// pops and compares them on every strobe.
module tb_rule_range_clear;
    localparam int IDX_W = 12;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] ctl_rd_data;
    logic        clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic        lookup_ok;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rule_range_clear dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en),
        .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .clr_en(clr_en), .clr_idx(clr_idx), .lookup_ok(lookup_ok)
    );

    function automatic logic [31:0] mk(int first, int last, bit go);
        return (32'(last) << 13) | (32'(first) << 1) | 32'(go);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Queue the indices a legal span should clear
    task automatic push_span(int first, int last);
        if (first <= last && last < DEPTH)
            for (int i = first; i <= last; i++) exp_q.push_back(i);
    endtask

    task automatic write_word(logic [31:0] w);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wr_data = w;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    // Count remaining busy cycles and confirm the queue drained
    task automatic wait_idle(string req, int exp_cycles);
        int cnt = 0;
        while (ctl_rd_data[0]) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp_cycles, req, cnt, exp_cycles);
        check(exp_q.size() == 0, "R4 leftover", exp_q.size(), 0);
    endtask

    task automatic run_span(string req, int first, int last, int exp_cycles);
        push_span(first, last);
        write_word(mk(first, last, 1'b1));
        wait_idle(req, exp_cycles);
        check(ctl_rd_data == mk(first, last, 1'b0), "R2 readback",
              ctl_rd_data, mk(first, last, 1'b0));
    endtask

    // Monitor: compare each clear strobe with the scoreboard; check stall
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (clr_en) begin
                if (exp_q.size() == 0) check(1'b0, "R4 unexpected clear", clr_idx, 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(clr_idx) == e, "R4 index", clr_idx, e);
                end
            end
            if (ctl_rd_data[0]) check(!lookup_ok, "R10 stall", lookup_ok, 0);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ctl_rd_data == 0, "R1 readback", ctl_rd_data, 0);
        check(!clr_en, "R1 clr_en", clr_en, 0);
        check(lookup_ok, "R1 lookup_ok", lookup_ok, 1);

        run_span("R3 span 3..9", 3, 9, 7);
        run_span("R5 single", 5, 5, 1);
        run_span("R3 top edge", 250, 255, 6);
        run_span("R6 full table", 0, DEPTH - 1, DEPTH);
        run_span("R7 reversed", 20, 10, 1);
        run_span("R8 past end", 250, 256, 1);
        run_span("R8 far past end", 0, 4095, 1);

        // R9: second launch mid-walk is ignored
        push_span(10, 20);
        write_word(mk(10, 20, 1'b1));
        write_word(mk(0, 5, 1'b1));
        wait_idle("R9 busy write", 9);
        check(ctl_rd_data == mk(10, 20, 1'b0), "R9 readback",
              ctl_rd_data, mk(10, 20, 1'b0));

        // R11: launch bit at 0 does nothing
        write_word(mk(7, 8, 1'b0));
        check(!ctl_rd_data[0], "R11 not busy", ctl_rd_data[0], 0);
        @(negedge clk);
        check(ctl_rd_data == mk(10, 20, 1'b0), "R11 readback",
              ctl_rd_data, mk(10, 20, 1'b0));
        check(exp_q.size() == 0 && !clr_en, "R11 no clear", clr_en, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=idle");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule